// File: doc/BRIEF.md
# Split-Accumulator Systolic GF(2^m) Multiplier

This block multiplies two elements of the binary extension field GF(2^M) in polynomial basis. It reduces the product modulo x^M + P(x), where the low-order part P is an M-bit input supplied with every operand pair. Because P travels with its operands, consecutive products may use different moduli. The array works most-significant bit of B first.

The running remainder is not kept in a single register. It is split into two partial sums. One collects the shifted partial products b·A. The other collects the shifted reduction terms k·P, where the feedback bit k is the XOR of the two top bits from the previous row. The two updates in a row never depend on each other, so each bit of each partial sum costs one AND and one XOR per row. A final row XORs the two sums together.

Skew registers feed the operands into the array, and deskew registers line up the result bits. The result leaves in parallel with a valid flag. A new operand set can enter on every clock.

Top module: `gf2m_systolic_mul`

## Requirements
- R1: When out_valid is high, out_product equals in_a·in_b mod (x^M + in_p) for the operand set it belongs to. Bit j of in_a, in_b, in_p and out_product is the coefficient of x^j; the x^M term of the modulus is implied.
- R2: For an operand set sampled at rising edge n with in_valid high, out_valid is high and out_product holds its result in the cycle that follows rising edge n+3M. out_valid is high for exactly one cycle per accepted set.
- R3: A valid operand set can be presented on every clock without stalls. Results come out one per cycle, in input order, with none lost or repeated.
- R4: The modulus is taken per operand set: sets with different in_p in consecutive cycles are each reduced by their own in_p.
- R5: On a cycle with in_valid low, in_a, in_b and in_p are ignored and produce no result. While out_valid is low, out_product reads zero.
- R6: A synchronous active-high rst clears every pipeline stage. In the cycle after a reset edge, out_valid is 0 and out_product is 0, and operand sets in flight at that edge never appear.
- R7: If either operand is zero, the product is zero. If one operand is 1 (only bit 0 set), the product equals the other operand.
- R8: With M = 5 and in_p = 5'b00101 (modulus x^5+x^2+1), in_a = 5'b01011 times in_b = 5'b11010 gives 5'b00101.
- R9: M is a parameter (at least 2). The same description is exercised at M = 5 and at M = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| in_a | input | M | Multiplicand, bit j is coefficient of x^j |
| in_b | input | M | Multiplier, processed from bit M-1 down |
| in_p | input | M | Modulus terms below x^M |
| out_valid | output | 1 | Result present this cycle |
| out_product | output | M | Field product, zero when out_valid is low |

## Verification
The assertions take for granted that rst is high at the first clock edge. They also assume that in_a, in_b and in_p carry known values on every cycle where in_valid is high, since the bound model computes a product from whatever is sampled then. The bench holds rst from time zero and drives only known values, including random values on idle cycles. It keeps every modulus a primitive polynomial of degree 5 or 8, so each expected value is also a product in a true field.

// File: rtl/gf2m_systolic_mul.sv
module gf2m_systolic_mul #(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] in_a,
  input  logic [M-1:0] in_b,
  input  logic [M-1:0] in_p,
  output logic         out_valid,
  output logic [M-1:0] out_product
);
  localparam int LAT = 3 * M;

  logic [M-1:0] ra, rb, rp;
  logic         rv;
  logic [LAT-2:0] vch;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0; rb <= '0; rp <= '0; rv <= 1'b0; vch <= '0;
    end else begin
      rv  <= in_valid;
      vch <= {vch[LAT-3:0], rv};
      if (in_valid) begin
        ra <= in_a; rb <= in_b; rp <= in_p;
      end
    end
  end

  logic [M-1:0] a_row0, p_row0, b_row;

  for (genvar j = 0; j < M; j++) begin : g_opskew
    localparam int D = M - 1 - j;
    if (D == 0) begin : g_direct
      assign a_row0[j] = ra[j];
      assign p_row0[j] = rp[j];
    end else begin : g_chain
      logic [D-1:0] sa, sp;
      always_ff @(posedge clk) begin
        if (rst) begin
          sa <= '0; sp <= '0;
        end else begin
          sa[0] <= ra[j];
          sp[0] <= rp[j];
          for (int k = 1; k < D; k++) begin
            sa[k] <= sa[k-1];
            sp[k] <= sp[k-1];
          end
        end
      end
      assign a_row0[j] = sa[D-1];
      assign p_row0[j] = sp[D-1];
    end
  end

  for (genvar i = 0; i < M; i++) begin : g_bskew
    localparam int D = 2 * i;
    if (D == 0) begin : g_direct
      assign b_row[i] = rb[M-1-i];
    end else begin : g_chain
      logic [D-1:0] sb;
      always_ff @(posedge clk) begin
        if (rst) sb <= '0;
        else begin
          sb[0] <= rb[M-1-i];
          for (int k = 1; k < D; k++) sb[k] <= sb[k-1];
        end
      end
      assign b_row[i] = sb[D-1];
    end
  end

  logic [M-1:0] c_q [M];
  logic [M-1:0] d_q [M];
  logic [M-1:0] a1 [M-1];
  logic [M-1:0] a2 [M-1];
  logic [M-1:0] p1 [M-1];
  logic [M-1:0] p2 [M-1];
  logic [M-2:0] bq [M];
  logic [M-2:0] kq [M];
  logic [M-1:1] krow;

  logic [M-1:0] a_in [M];
  logic [M-1:0] p_in [M];
  logic [M-1:0] b_in [M];
  logic [M-1:0] k_in [M];
  logic [M-1:0] c_in [M];
  logic [M-1:0] d_in [M];

  always_comb begin
    for (int i = 0; i < M; i++) begin
      for (int j = 0; j < M; j++) begin
        if (i == 0) begin
          a_in[i][j] = a_row0[j];
          p_in[i][j] = p_row0[j];
        end else begin
          a_in[i][j] = a2[(i == 0) ? 0 : i-1][j];
          p_in[i][j] = p2[(i == 0) ? 0 : i-1][j];
        end
        if (j == M-1) begin
          b_in[i][j] = b_row[i];
          k_in[i][j] = (i != 0) && krow[(i == 0) ? 1 : i];
        end else begin
          b_in[i][j] = bq[i][(j == M-1) ? 0 : j];
          k_in[i][j] = kq[i][(j == M-1) ? 0 : j];
        end
        if (i == 0 || j == 0) begin
          c_in[i][j] = 1'b0;
          d_in[i][j] = 1'b0;
        end else begin
          c_in[i][j] = c_q[(i == 0) ? 0 : i-1][(j == 0) ? 0 : j-1];
          d_in[i][j] = d_q[(i == 0) ? 0 : i-1][(j == 0) ? 0 : j-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      krow <= '0;
      for (int i = 0; i < M; i++) begin
        c_q[i] <= '0; d_q[i] <= '0; bq[i] <= '0; kq[i] <= '0;
      end
      for (int i = 0; i < M-1; i++) begin
        a1[i] <= '0; a2[i] <= '0; p1[i] <= '0; p2[i] <= '0;
      end
    end else begin
      for (int i = 0; i < M; i++) begin
        c_q[i] <= c_in[i] ^ (b_in[i] & a_in[i]);
        d_q[i] <= d_in[i] ^ (k_in[i] & p_in[i]);
        bq[i]  <= b_in[i][M-1:1];
        kq[i]  <= k_in[i][M-1:1];
      end
      for (int i = 0; i < M-1; i++) begin
        a1[i] <= a_in[i]; a2[i] <= a1[i];
        p1[i] <= p_in[i]; p2[i] <= p1[i];
      end
      for (int i = 1; i < M; i++)
        krow[i] <= c_q[i-1][M-1] ^ d_q[i-1][M-1];
    end
  end

  logic [M-1:0] w_q, w_al;

  always_ff @(posedge clk) begin
    if (rst) w_q <= '0;
    else     w_q <= c_q[M-1] ^ d_q[M-1];
  end

  for (genvar j = 0; j < M; j++) begin : g_deskew
    if (j == 0) begin : g_direct
      assign w_al[j] = w_q[j];
    end else begin : g_chain
      logic [j-1:0] sw;
      always_ff @(posedge clk) begin
        if (rst) sw <= '0;
        else begin
          sw[0] <= w_q[j];
          for (int k = 1; k < j; k++) sw[k] <= sw[k-1];
        end
      end
      assign w_al[j] = sw[j-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else begin
      out_valid   <= vch[LAT-2];
      out_product <= vch[LAT-2] ? w_al : '0;
    end
  end
endmodule

// File: rtl/gf2m_mul_props.sv
module gf2m_mul_props #(
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] in_a,
  input logic [M-1:0] in_b,
  input logic [M-1:0] in_p,
  input logic         out_valid,
  input logic [M-1:0] out_product
);
  localparam int LAT = 3 * M;

  function automatic logic [M-1:0] msb_first(input logic [M-1:0] a,
                                             input logic [M-1:0] b,
                                             input logic [M-1:0] p);
    logic [M-1:0] t;
    logic         top;
    t = '0;
    for (int i = M-1; i >= 0; i--) begin
      top = t[M-1];
      t = {t[M-2:0], 1'b0};
      if (top)  t = t ^ p;
      if (b[i]) t = t ^ a;
    end
    return t;
  endfunction

  logic         ev [LAT+1];
  logic [M-1:0] ep [LAT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= LAT; k++) begin
        ev[k] <= 1'b0; ep[k] <= '0;
      end
    end else begin
      ev[0] <= in_valid;
      ep[0] <= msb_first(in_a, in_b, in_p);
      for (int k = 1; k <= LAT; k++) begin
        ev[k] <= ev[k-1]; ep[k] <= ep[k-1];
      end
    end
  end

  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_product == ep[LAT]);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == ev[LAT]);

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_product == '0);

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_product == '0));
endmodule

bind gf2m_systolic_mul gf2m_mul_props #(.M(M)) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
  .in_p(in_p), .out_valid(out_valid), .out_product(out_product)
);

// File: tb/gf2m_systolic_mul_test.sv
`timescale 1ns/1ps
module gf2m_systolic_mul_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic       iv8, ov8;
  logic [7:0] a8, b8, p8, o8;
  logic       iv5, ov5;
  logic [4:0] a5, b5, p5, o5;

  gf2m_systolic_mul #(.M(8)) uut (
    .clk(clk), .rst(rst), .in_valid(iv8), .in_a(a8), .in_b(b8), .in_p(p8),
    .out_valid(ov8), .out_product(o8));

  gf2m_systolic_mul #(.M(5)) uut_m5 (
    .clk(clk), .rst(rst), .in_valid(iv5), .in_a(a5), .in_b(b5), .in_p(p5),
    .out_valid(ov5), .out_product(o5));

  int nchk = 0, nfail = 0, cyc = 0;
  bit mon_on = 1'b0, done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] exp8[$], exp5[$];
  int         due8[$], due5[$];
  string      tag8[$], tag5[$];

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b,
                                      input logic [7:0] p, input int m);
    logic [7:0] acc, sh, mask;
    logic       hi;
    mask = 8'((16'd1 << m) - 1);
    acc = '0;
    sh = a & mask;
    for (int j = 0; j < m; j++) begin
      if (b[j]) acc = acc ^ sh;
      hi = sh[m-1];
      sh = (sh << 1) & mask;
      if (hi) sh = sh ^ (p & mask);
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push8(input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] p, input string tag);
    @(posedge clk); #1;
    iv8 = 1'b1; a8 = a; b8 = b; p8 = p;
    exp8.push_back(gmul(a, b, p, 8));
    due8.push_back(cyc + 1 + 3*8);
    tag8.push_back(tag);
  endtask

  task automatic push5(input logic [4:0] a, input logic [4:0] b,
                       input logic [4:0] p, input logic [4:0] want, input string tag);
    @(posedge clk); #1;
    iv5 = 1'b1; a5 = a; b5 = b; p5 = p;
    exp5.push_back({3'b000, want});
    due5.push_back(cyc + 1 + 3*5);
    tag5.push_back(tag);
  endtask

  task automatic idle8(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      iv8 = 1'b0; a8 = 8'($urandom); b8 = 8'($urandom); p8 = 8'($urandom);
    end
  endtask

  task automatic idle5(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      iv5 = 1'b0; a5 = 5'($urandom); b5 = 5'($urandom); p5 = 5'($urandom);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (ov8) begin
      if (exp8.size() == 0) chk(1'b0, "R5", "m8 result with nothing pending", 1, 0);
      else begin
        logic [7:0] e; int d; string t;
        e = exp8.pop_front(); d = due8.pop_front(); t = tag8.pop_front();
        chk(o8 == e, t, "m8 product", o8, e);
        chk(cyc == d, "R2", "m8 result cycle", cyc, d);
      end
    end else chk(o8 == 8'h00, "R5", "m8 idle output", o8, 0);
    if (ov5) begin
      if (exp5.size() == 0) chk(1'b0, "R5", "m5 result with nothing pending", 1, 0);
      else begin
        logic [7:0] e; int d; string t;
        e = exp5.pop_front(); d = due5.pop_front(); t = tag5.pop_front();
        chk({3'b000, o5} == e, t, "m5 product", o5, e);
        chk(cyc == d, "R2", "m5 result cycle", cyc, d);
      end
    end else chk(o5 == 5'h00, "R5", "m5 idle output", o5, 0);
  end

  task automatic run_m8;
    logic [7:0] x, y;
    x = 8'($urandom) | 8'h01; y = 8'($urandom);
    push8(8'h00, y, 8'h1D, "R7");
    push8(x, 8'h00, 8'h1D, "R7");
    push8(x, 8'h01, 8'h1D, "R7");
    push8(8'h01, y, 8'h1D, "R7");
    push8(8'hFF, 8'hFF, 8'h1D, "R7");
    for (int k = 0; k < 150; k++)
      push8(8'($urandom), 8'($urandom), 8'h1D, "R3");
    for (int k = 0; k < 100; k++)
      push8(8'($urandom), 8'($urandom), (k % 2 == 0) ? 8'h1D : 8'h2B, "R4");
    for (int k = 0; k < 60; k++) begin
      push8(8'($urandom), 8'($urandom), 8'h2B, "R1");
      idle8(1 + (k % 3));
    end
    idle8(3*8 + 6);
  endtask

  task automatic run_m5;
    push5(5'b01011, 5'b11010, 5'b00101, 5'b00101, "R8");
    for (int k = 0; k < 120; k++) begin
      logic [4:0] a, b, p;
      a = 5'($urandom); b = 5'($urandom); p = (k % 3 == 0) ? 5'b01001 : 5'b00101;
      push5(a, b, p, 5'(gmul({3'b0, a}, {3'b0, b}, {3'b0, p}, 5)), "R9");
      if (k % 7 == 0) idle5(2);
    end
    idle5(3*5 + 6);
  endtask

  initial begin
    iv8 = 1'b1; a8 = 8'hA5; b8 = 8'h5A; p8 = 8'h1D;
    iv5 = 1'b1; a5 = 5'h15; b5 = 5'h0A; p5 = 5'h05;
    repeat (4) @(posedge clk);
    #1;
    chk(!ov8 && o8 == 8'h00, "R6", "m8 outputs in reset", {ov8, o8}, 0);
    chk(!ov5 && o5 == 5'h00, "R6", "m5 outputs in reset", {ov5, o5}, 0);
    rst = 1'b0; iv8 = 1'b0; iv5 = 1'b0; mon_on = 1'b1;

    fork
      run_m8;
      run_m5;
    join
    chk(exp8.size() == 0, "R3", "m8 results outstanding", exp8.size(), 0);
    chk(exp5.size() == 0, "R3", "m5 results outstanding", exp5.size(), 0);

    for (int k = 0; k < 6; k++) push8(8'($urandom), 8'($urandom), 8'h1D, "R6");
    for (int k = 0; k < 6; k++) push5(5'($urandom), 5'($urandom), 5'h05, 5'h00, "R6");
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    exp8.delete(); due8.delete(); tag8.delete();
    exp5.delete(); due5.delete(); tag5.delete();
    chk(!ov8 && o8 == 8'h00, "R6", "m8 outputs after reset edge", {ov8, o8}, 0);
    chk(!ov5 && o5 == 5'h00, "R6", "m5 outputs after reset edge", {ov5, o5}, 0);
    iv8 = 1'b0; iv5 = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    idle8(3*8 + 6);

    push8(8'h57, 8'h83, 8'h1D, "R1");
    push8(8'h80, 8'h80, 8'h1D, "R1");
    idle8(3*8 + 6);
    chk(exp8.size() == 0, "R3", "m8 results outstanding at end", exp8.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R3 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule